// File: doc/BRIEF.md
# Halfword-Packing Burst Write Master

This block accepts a stream of 16-bit halfwords and stores them in memory over a 32-bit AXI4 write path. It joins neighbouring halfwords into 32-bit words and queues them in an internal word buffer. Once enough words are queued for a full burst, it issues that burst with every beat at full bus width. It never falls back to 2-byte transfers.

A job begins with a command that carries a byte start address and a halfword count. The start address may sit on a halfword boundary inside a word. In that case the first beat enables only the upper byte lanes. A trailing odd halfword goes out in the lower byte lanes. Bursts never exceed a fixed beat cap and never cross a 4 KB page. A last flag on the input can end the job before the count is used up. The words already queued then go out as a shorter final burst. Any write response other than OKAY raises a sticky error flag.

Top module: `hw_pack_wr_master`

## Requirements
- R1: With a word-aligned start, halfwords k and k+1 of the stream form one beat with halfword k in bits 15:0, halfword k+1 in bits 31:16, and strobe 4'b1111.
- R2: When start address bit 1 is set, the first beat goes to the word address (start with bits 1:0 cleared), carries the first halfword in bits 31:16, and has strobe 4'b1100.
- R3: A final halfword with no partner is placed in bits 15:0 with strobe 4'b0011.
- R4: Every address beat carries AWSIZE = 3'b010 (four bytes) and AWBURST = 2'b01 (incrementing).
- R5: AWLEN equals the beat count of the burst minus one, and WLAST is high on exactly the last beat of each burst.
- R6: A burst has at most MAX_BEATS beats and does not cross a 4096-byte boundary. Its length is the smaller of that limit and the number of words still to be written in the job.
- R7: Once AWVALID or WVALID is raised, it stays high with a stable payload until the matching ready is seen.
- R8: The job ends when the command's halfword count is consumed or when a halfword with in_last set is accepted, whichever comes first. The partial burst is then flushed.
- R9: A write response other than 2'b00 sets err, and err stays set until reset.
- R10: in_ready is low while no job is active and while the word buffer holds BUF_WORDS words. With a word-aligned start and a stalled address channel, exactly 2*BUF_WORDS halfwords are accepted.
- R11: After reset, cmd_ready is high and in_ready, AWVALID, WVALID and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Job command valid |
| cmd_ready | output | 1 | High while no job is active |
| cmd_addr | input | ADDR_W | Byte start address; bit 0 is taken as zero |
| cmd_len | input | LEN_W | Halfword count of the job, nonzero |
| in_valid | input | 1 | Halfword valid |
| in_ready | output | 1 | Halfword accepted when high with in_valid |
| in_data | input | 16 | Halfword data |
| in_last | input | 1 | Marks the final halfword of the job |
| m_awvalid | output | 1 | Address channel valid |
| m_awready | input | 1 | Address channel ready |
| m_awaddr | output | ADDR_W | Burst start address, word aligned |
| m_awlen | output | 8 | Beats minus one |
| m_awsize | output | 3 | Beat size code, always four bytes |
| m_awburst | output | 2 | Burst type, always incrementing |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Byte lane enables |
| m_wlast | output | 1 | Final beat of burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |
| err | output | 1 | Sticky error flag |

## Verification
The hardest case to reach from the ports is a full word buffer with its first burst still waiting for the address channel. The bench holds AWREADY low for the whole input phase of one job and streams halfwords without gaps until in_ready stays low. It counts the accepted halfwords and then releases the channel. A second difficult case is a halfword-offset start just below a 4 KB page boundary, which forces a short first burst with a half strobe. The bench places job start addresses a few words below a page edge, and AXI ready signals toggle pseudo-randomly throughout the run.

// File: rtl/hwpk_pkg.sv
package hwpk_pkg;

    localparam int          HALF_W     = 16;
    localparam int          WORD_W     = 32;
    localparam int          PAGE_WORDS = 1024;
    localparam logic [2:0]  SIZE_WORD  = 3'd2;
    localparam logic [1:0]  BURST_INCR = 2'b01;
    localparam logic [1:0]  RESP_OKAY  = 2'b00;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [3:0]        strb;
    } beat_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_ADDR,
        ST_DATA,
        ST_RESP
    } ctl_state_e;

    function automatic logic [10:0] min11(input logic [10:0] a, input logic [10:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/hwpk_packer.sv
module hwpk_packer
    import hwpk_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_upper,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              in_valid,
    input  logic [HALF_W-1:0] in_data,
    input  logic              in_last,
    input  logic              space_ok,
    output logic              in_ready,
    output logic              push,
    output beat_t             push_beat,
    output logic              src_done
);

    logic              active_q;
    logic              phase_q;     // 1: next halfword lands in the upper lanes
    logic              first_up_q;  // upper-only first beat pending
    logic [HALF_W-1:0] lo_q;
    logic [LEN_W-1:0]  rem_q;
    logic              take;
    logic              final_hw;

    assign in_ready = active_q && space_ok;
    assign take     = in_valid && in_ready;
    assign final_hw = in_last || (rem_q == LEN_W'(1));
    assign push     = take && (phase_q || final_hw);
    assign src_done = !active_q;

    always_comb begin
        if (phase_q) begin
            push_beat.data = {in_data, first_up_q ? {HALF_W{1'b0}} : lo_q};
            push_beat.strb = first_up_q ? 4'b1100 : 4'b1111;
        end else begin
            push_beat.data = {{HALF_W{1'b0}}, in_data};
            push_beat.strb = 4'b0011;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            phase_q    <= 1'b0;
            first_up_q <= 1'b0;
            lo_q       <= '0;
            rem_q      <= '0;
        end else if (start) begin
            active_q   <= 1'b1;
            phase_q    <= start_upper;
            first_up_q <= start_upper;
            rem_q      <= start_len;
        end else if (take) begin
            rem_q <= rem_q - LEN_W'(1);
            if (final_hw) active_q <= 1'b0;
            if (phase_q) begin
                phase_q    <= 1'b0;
                first_up_q <= 1'b0;
            end else begin
                lo_q    <= in_data;
                phase_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hwpk_fifo.sv
module hwpk_fifo
    import hwpk_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  beat_t            push_beat,
    input  logic             pop,
    output beat_t            head,
    output logic [CNT_W-1:0] count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    beat_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_q;
    logic [PTR_W-1:0] rd_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign head  = mem[rd_q];
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= push_beat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/hwpk_burst_ctl.sv
module hwpk_burst_ctl
    import hwpk_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_BEATS = 16,
    parameter int CNT_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  buf_count,
    input  logic              src_done,
    input  logic              awready,
    input  logic              wready,
    input  logic              bvalid,
    input  logic [1:0]        bresp,
    output logic              cmd_ready,
    output logic              awvalid,
    output logic [ADDR_W-1:0] awaddr,
    output logic [7:0]        awlen,
    output logic              wvalid,
    output logic              wlast,
    output logic              pop,
    output logic              bready,
    output logic              err
);

    localparam logic [10:0] CAP = 11'(MAX_BEATS);

    ctl_state_e        st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        len_q;
    logic [7:0]        beat_q;
    logic              err_q;

    logic [10:0] words_left;
    logic [10:0] plan;
    logic [10:0] have;
    logic        go;
    logic [7:0]  take_n;

    assign words_left = 11'(PAGE_WORDS) - {1'b0, addr_q[11:2]};
    assign plan       = min11(words_left, CAP);
    assign have       = 11'(buf_count);
    assign go         = (have >= plan) || (src_done && (have != 11'd0));
    assign take_n     = 8'((have >= plan) ? plan : have);

    assign cmd_ready = (st_q == ST_IDLE);
    assign awvalid   = (st_q == ST_ADDR);
    assign awaddr    = addr_q;
    assign awlen     = len_q;
    assign wvalid    = (st_q == ST_DATA);
    assign wlast     = wvalid && (beat_q == len_q);
    assign pop       = wvalid && wready;
    assign bready    = (st_q == ST_RESP);
    assign err       = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            len_q  <= '0;
            beat_q <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    addr_q <= start_addr & ~ADDR_W'(3);
                    st_q   <= ST_COLLECT;
                end
                ST_COLLECT: if (go) begin
                    len_q <= take_n - 8'd1;
                    st_q  <= ST_ADDR;
                end
                ST_ADDR: if (awready) begin
                    addr_q <= addr_q + ADDR_W'({len_q, 2'b00}) + ADDR_W'(4);
                    beat_q <= '0;
                    st_q   <= ST_DATA;
                end
                ST_DATA: if (wready) begin
                    beat_q <= beat_q + 8'd1;
                    if (beat_q == len_q) st_q <= ST_RESP;
                end
                ST_RESP: if (bvalid) begin
                    if (bresp != RESP_OKAY) err_q <= 1'b1;
                    st_q <= (src_done && (buf_count == '0)) ? ST_IDLE : ST_COLLECT;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hw_pack_wr_master.sv
module hw_pack_wr_master
    import hwpk_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MAX_BEATS = 16,
    parameter int BUF_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [15:0]       in_data,
    input  logic              in_last,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic [7:0]        m_awlen,
    output logic [2:0]        m_awsize,
    output logic [1:0]        m_awburst,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [31:0]       m_wdata,
    output logic [3:0]        m_wstrb,
    output logic              m_wlast,
    input  logic              m_bvalid,
    output logic              m_bready,
    input  logic [1:0]        m_bresp,
    output logic              err
);

    localparam int CNT_W = $clog2(BUF_WORDS + 1);

    logic             start;
    logic             space_ok;
    logic             push;
    logic             pop;
    logic             src_done;
    beat_t            push_beat;
    beat_t            head;
    logic [CNT_W-1:0] buf_count;

    assign start     = cmd_valid && cmd_ready;
    assign space_ok  = (buf_count < CNT_W'(BUF_WORDS));
    assign m_awsize  = SIZE_WORD;
    assign m_awburst = BURST_INCR;
    assign m_wdata   = head.data;
    assign m_wstrb   = head.strb;

    hwpk_packer #(.LEN_W(LEN_W)) u_pack (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_upper(cmd_addr[1]),
        .start_len  (cmd_len),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .space_ok   (space_ok),
        .in_ready   (in_ready),
        .push       (push),
        .push_beat  (push_beat),
        .src_done   (src_done)
    );

    hwpk_fifo #(.DEPTH(BUF_WORDS), .CNT_W(CNT_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_beat(push_beat),
        .pop      (pop),
        .head     (head),
        .count    (buf_count)
    );

    hwpk_burst_ctl #(.ADDR_W(ADDR_W), .MAX_BEATS(MAX_BEATS), .CNT_W(CNT_W)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_addr(cmd_addr),
        .buf_count (buf_count),
        .src_done  (src_done),
        .awready   (m_awready),
        .wready    (m_wready),
        .bvalid    (m_bvalid),
        .bresp     (m_bresp),
        .cmd_ready (cmd_ready),
        .awvalid   (m_awvalid),
        .awaddr    (m_awaddr),
        .awlen     (m_awlen),
        .wvalid    (m_wvalid),
        .wlast     (m_wlast),
        .pop       (pop),
        .bready    (m_bready),
        .err       (err)
    );

endmodule

// File: rtl/hw_pack_wr_master_chk.sv
module hw_pack_wr_master_chk #(
    parameter int ADDR_W    = 32,
    parameter int MAX_BEATS = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_ready,
    input logic              in_ready,
    input logic              awvalid,
    input logic              awready,
    input logic [ADDR_W-1:0] awaddr,
    input logic [7:0]        awlen,
    input logic              wvalid,
    input logic              wready,
    input logic [31:0]       wdata,
    input logic [3:0]        wstrb,
    input logic              wlast,
    input logic              bvalid,
    input logic              bready,
    input logic [1:0]        bresp,
    input logic              err
);

    logic [7:0] len_c;
    logic [7:0] cnt_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_c <= '0;
            cnt_c <= '0;
        end else if (awvalid && awready) begin
            len_c <= awlen;
            cnt_c <= '0;
        end else if (wvalid && wready) begin
            cnt_c <= cnt_c + 8'd1;
        end
    end

    p_aw_hold_r7: assert property (@(posedge clk) disable iff (rst)
        awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen));

    p_w_hold_r7: assert property (@(posedge clk) disable iff (rst)
        wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wstrb) && $stable(wlast));

    p_page_cap_r6: assert property (@(posedge clk) disable iff (rst)
        awvalid |-> (({2'b00, awaddr[11:0]} + {4'b0000, awlen, 2'b00} + 14'd4) <= 14'd4096)
                    && (awlen < 8'(MAX_BEATS)));

    p_wlast_pos_r5: assert property (@(posedge clk) disable iff (rst)
        wvalid |-> (wlast == (cnt_c == len_c)));

    p_err_set_r9: assert property (@(posedge clk) disable iff (rst)
        bvalid && bready && (bresp != 2'b00) |=> err);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    p_idle_no_input_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !in_ready);

endmodule

bind hw_pack_wr_master hw_pack_wr_master_chk #(
    .ADDR_W   (ADDR_W),
    .MAX_BEATS(MAX_BEATS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_ready(cmd_ready),
    .in_ready (in_ready),
    .awvalid  (m_awvalid),
    .awready  (m_awready),
    .awaddr   (m_awaddr),
    .awlen    (m_awlen),
    .wvalid   (m_wvalid),
    .wready   (m_wready),
    .wdata    (m_wdata),
    .wstrb    (m_wstrb),
    .wlast    (m_wlast),
    .bvalid   (m_bvalid),
    .bready   (m_bready),
    .bresp    (m_bresp),
    .err      (err)
);

// File: tb/hw_pack_wr_master_test.sv
`timescale 1ns/1ps
module hw_pack_wr_master_test;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int MAXB   = 16;
    localparam int BUFW   = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [15:0]       in_data = '0;
    logic              in_last = 1'b0;
    logic              awvalid, awready;
    logic [ADDR_W-1:0] awaddr;
    logic [7:0]        awlen;
    logic [2:0]        awsize;
    logic [1:0]        awburst;
    logic              wvalid, wready;
    logic [31:0]       wdata;
    logic [3:0]        wstrb;
    logic              wlast;
    logic              bvalid, bready;
    logic [1:0]        bresp;
    logic              err;

    always #2.5 clk = ~clk;

    hw_pack_wr_master #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BEATS(MAXB), .BUF_WORDS(BUFW)) uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .m_awvalid(awvalid), .m_awready(awready), .m_awaddr(awaddr), .m_awlen(awlen),
        .m_awsize(awsize), .m_awburst(awburst),
        .m_wvalid(wvalid), .m_wready(wready), .m_wdata(wdata), .m_wstrb(wstrb), .m_wlast(wlast),
        .m_bvalid(bvalid), .m_bready(bready), .m_bresp(bresp), .err(err)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    int unsigned q_aw_addr[$];
    int          q_aw_len[$];
    logic [31:0] q_w_data[$];
    logic [3:0]  q_w_strb[$];
    bit          q_w_last[$];
    logic [15:0] hw[$];
    string       cur_tag = "R11";
    bit          stall_aw = 0;
    bit          bad_resp_next = 0;
    int          b_pending = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference: place each halfword by its byte address, then split into bursts.
    task automatic plan_job(input int unsigned addr, input int n);
        int unsigned fw, lw, cur;
        int nw, left, k;
        logic [31:0] wd[];
        logic [3:0]  ws[];
        fw = addr >> 2;
        lw = (addr + 2 * n - 1) >> 2;
        nw = int'(lw - fw) + 1;
        wd = new[nw];
        ws = new[nw];
        for (int j = 0; j < nw; j++) begin
            wd[j] = '0;
            ws[j] = '0;
        end
        for (int i = 0; i < n; i++) begin
            int unsigned ba;
            int idx;
            ba  = addr + 2 * i;
            idx = int'((ba >> 2) - fw);
            if (ba[1]) begin
                wd[idx][31:16] = hw[i];
                ws[idx] = ws[idx] | 4'b1100;
            end else begin
                wd[idx][15:0] = hw[i];
                ws[idx] = ws[idx] | 4'b0011;
            end
        end
        cur = fw; left = nw; k = 0;
        while (left > 0) begin
            int room, len;
            room = 1024 - int'(cur % 1024);
            len  = (room < MAXB) ? room : MAXB;
            if (left < len) len = left;
            q_aw_addr.push_back(cur << 2);
            q_aw_len.push_back(len - 1);
            for (int b = 0; b < len; b++) begin
                q_w_data.push_back(wd[k + b]);
                q_w_strb.push_back(ws[k + b]);
                q_w_last.push_back(b == len - 1);
            end
            cur += len; left -= len; k += len;
        end
    endtask

    task automatic run_job(input int unsigned addr, input int len, input int n_send,
                           input string tag, input bit stall);
        int i, low_cnt;
        bit st;
        if (n_send > len) n_send = len;
        cur_tag = tag;
        hw.delete();
        for (int j = 0; j < n_send; j++) hw.push_back(16'((addr >> 4) ^ (j * 37) ^ 16'h5A00));
        plan_job(addr, n_send);
        st = stall;
        stall_aw = stall;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = addr; cmd_len = LEN_W'(len);
        #1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        cmd_valid = 1'b0;
        i = 0; low_cnt = 0;
        while (i < n_send) begin
            in_valid = st || ($urandom % 5 != 0);
            in_data  = hw[i];
            in_last  = (i == n_send - 1) && (n_send < len);
            #1;
            if (in_valid && in_ready) begin
                i++;
                low_cnt = 0;
            end else if (st && !in_ready) begin
                low_cnt++;
            end
            if (st && low_cnt == 30) begin
                chk(i == 2 * BUFW, "R10", "halfwords accepted under address stall", 64'(i), 64'(2 * BUFW));
                st = 0;
                stall_aw = 0;
            end
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
        #1;
        while (q_aw_addr.size() != 0 || q_w_data.size() != 0 || b_pending != 0 || !cmd_ready) begin
            @(negedge clk); #1;
        end
        chk(!in_ready, "R10", "in_ready after job end", 64'(in_ready), 64'(0));
    endtask

    // Slave model and per-clock protocol comparison.
    initial begin
        bit aw_wait, w_wait, b_hs;
        logic [ADDR_W-1:0] aw_a;
        logic [7:0] aw_l;
        logic [31:0] w_d;
        logic [3:0] w_s;
        logic w_l;
        aw_wait = 0; w_wait = 0; b_hs = 0;
        awready = 0; wready = 0; bvalid = 0; bresp = 2'b00;
        forever begin
            @(negedge clk);
            if (b_hs) begin bvalid = 1'b0; b_hs = 0; end
            if (!bvalid && b_pending > 0) begin
                bvalid = 1'b1;
                bresp  = bad_resp_next ? 2'b10 : 2'b00;
                bad_resp_next = 0;
            end
            awready = stall_aw ? 1'b0 : ($urandom % 3 != 0);
            wready  = ($urandom % 4 != 0);
            #1;
            if (!rst) begin
                if (aw_wait)
                    chk(awvalid && awaddr == aw_a && awlen == aw_l, "R7", "address held while stalled",
                        {awvalid, 23'd0, awlen, awaddr}, {1'b1, 23'd0, aw_l, aw_a});
                if (w_wait)
                    chk(wvalid && wdata == w_d && wstrb == w_s && wlast == w_l, "R7", "data held while stalled",
                        {27'd0, wvalid, wlast, wstrb, wdata}, {27'd0, 1'b1, w_l, w_s, w_d});
                if (awvalid && awready) begin
                    if (q_aw_addr.size() == 0) begin
                        chk(0, "R6", "unexpected burst", 64'(awaddr), 64'(0));
                    end else begin
                        int unsigned ea;
                        int el;
                        ea = q_aw_addr.pop_front();
                        el = q_aw_len.pop_front();
                        chk(awaddr == ea, cur_tag, "burst address R2/R6", 64'(awaddr), 64'(ea));
                        chk(int'(awlen) == el, "R5/R6", "burst length field", 64'(awlen), 64'(el));
                        chk(awsize == 3'd2 && awburst == 2'b01, "R4", "size/burst codes",
                            {59'd0, awsize, awburst}, {59'd0, 3'd2, 2'b01});
                    end
                end
                if (wvalid && wready) begin
                    if (q_w_data.size() == 0) begin
                        chk(0, "R5", "unexpected beat", 64'(wdata), 64'(0));
                    end else begin
                        logic [31:0] ed;
                        logic [3:0] es;
                        bit el2;
                        ed = q_w_data.pop_front();
                        es = q_w_strb.pop_front();
                        el2 = q_w_last.pop_front();
                        chk(wdata == ed && wstrb == es, cur_tag, "beat data/strobe R1/R2/R3",
                            {28'd0, wstrb, wdata}, {28'd0, es, ed});
                        chk(wlast == el2, "R5", "last flag", 64'(wlast), 64'(el2));
                    end
                    if (wlast) b_pending++;
                end
                if (bvalid && bready) begin
                    b_hs = 1;
                    b_pending--;
                end
            end
            aw_wait = awvalid && !awready;
            aw_a = awaddr; aw_l = awlen;
            w_wait = wvalid && !wready;
            w_d = wdata; w_s = wstrb; w_l = wlast;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        chk(cmd_ready == 1'b1, "R11", "cmd_ready after reset", 64'(cmd_ready), 64'(1));
        chk(!in_ready && !awvalid && !wvalid, "R11", "in_ready/awvalid/wvalid after reset",
            {61'd0, in_ready, awvalid, wvalid}, 64'(0));
        chk(err == 1'b0, "R11", "err after reset", 64'(err), 64'(0));

        run_job(32'h0000_1000, 8, 8, "R1", 0);
        run_job(32'h0000_2002, 6, 6, "R2/R3", 0);
        run_job(32'h0000_3000, 70, 70, "R6", 0);
        run_job(32'h0000_4FF2, 40, 40, "R2/R6", 0);
        run_job(32'h0000_6000, 100, 9, "R8/R3", 0);
        run_job(32'h0000_7000, 40, 40, "R10", 1);
        chk(err == 1'b0, "R9", "err clear after OKAY responses", 64'(err), 64'(0));
        bad_resp_next = 1;
        run_job(32'h0000_8000, 4, 4, "R9", 0);
        chk(err == 1'b1, "R9", "err set by error response", 64'(err), 64'(1));
        run_job(32'h0000_9006, 5, 5, "R9", 0);
        chk(err == 1'b1, "R9", "err held after later OKAY", 64'(err), 64'(1));

        chk(q_aw_addr.size() == 0 && q_w_data.size() == 0, "R8", "all expected traffic seen",
            64'(q_aw_addr.size() + q_w_data.size()), 64'(0));
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule